// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a CPU bus and looks at one bus-cycle descriptor per clock: a 32-bit virtual address, an 8-bit address-space identifier, 64 bits of data, an instruction/operand flag, a read/write flag and a two-bit access size. Two comparator channels, A and B, each hold their own address, identifier, cycle-type, direction and size conditions. Channel B also compares the low 32 bits of the bus data against a value under a per-bit don't-care mask.

A channel that matches sets a sticky flag, and the break request output is high while any flag is set. In independent mode each channel sets its own flag. In sequential mode a channel A match only arms the block, and a later channel B match fires. Software loads the conditions through a small register write port and clears the flags with write-one-to-clear. For instruction-fetch matches, each channel carries a bit that chooses whether the break is taken before the instruction runs or after it completes. That choice is reported alongside the request.

Register write port (`cfgAddr`): 0 channel A address, 1 channel A control, 2 channel B address, 3 channel B control, 4 channel B data value, 5 channel B data mask, 6 mode (bit 0 = sequential), 7 flag clear (bit 0 clears flag A, bit 1 clears flag B). The control word layout is: bit 20 enable, bit 19 break-after, bit 18 size-any, bits 17:16 size, bits 15:14 direction, bits 13:12 cycle type, bits 11:4 identifier, bit 3 identifier-any, bits 2:0 address mask code. All registers reset to zero.

Top module: `brkUnit`

## Requirements
- R1: The address mask code selects which address bits are compared: 0 all bits, 1 ignore bits 9:0, 2 ignore bits 11:0, 3 ignore bits 15:0, 4 ignore bits 19:0, 5 (and 6, 7) ignore every bit.
- R2: With identifier-any = 0 a channel matches only if `busAsid` equals its identifier field; with identifier-any = 1 the identifier is ignored.
- R3: Cycle type code 01 matches only instruction fetches (`busIsInsn`=1), code 10 only operand cycles, and codes 00 and 11 match either.
- R4: Direction code 01 matches only reads (`busIsWrite`=0), code 10 only writes, and codes 00 and 11 match either.
- R5: With size-any = 0 a channel matches only when `busSize` equals its size field (0 byte, 1 word, 2 longword, 3 quadword); with size-any = 1 size is ignored.
- R6: Channel B additionally requires `busData[31:0]` to equal its data value on every bit whose mask bit is 0. Mask bits set to 1 are don't-care, and `busData[63:32]` is never compared.
- R7: A channel with enable = 0 never matches, and a cycle with `busValid` low never matches.
- R8: In independent mode (mode bit 0 = 0) a match on a channel sets that channel's flag at the next clock edge, and `brkReq` is high whenever either flag is set.
- R9: In sequential mode a channel A match sets no flag and only arms the block. A channel B match sets flag B only if the block was already armed, and firing clears the arm state.
- R10: In sequential mode a single cycle that matches both channels while the block is unarmed arms it but does not set flag B. The next matching B cycle then fires.
- R11: Any write to registers 0 through 6 disarms the sequential state.
- R12: Flags are sticky and are cleared only by writing a 1 to their bit of register 7. Clearing one flag leaves the other unchanged.
- R13: When a flag is set by an instruction-fetch match on a channel whose break-after bit is 1, `brkAfter` is high while that flag is set. A flag set by an operand match, or by a channel with break-after = 0, leaves `brkAfter` low.
- R14: After reset both flags, `brkReq` and `brkAfter` are low, and mode is independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index |
| cfgWrData | input | 32 | Register write data |
| busValid | input | 1 | Bus cycle present this clock |
| busAddr | input | 32 | Virtual address of the cycle |
| busAsid | input | 8 | Address-space identifier of the cycle |
| busData | input | 64 | Data of the cycle |
| busIsInsn | input | 1 | 1 = instruction fetch, 0 = operand access |
| busIsWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code |
| brkReq | output | 1 | Break interrupt request |
| brkAfter | output | 1 | Break qualifier: 1 = take after instruction |
| flagA | output | 1 | Channel A sticky match flag |
| flagB | output | 1 | Channel B sticky match flag |

## Verification
The bench sets each address mask code and drives addresses just inside and just outside the ignored bit range. A design with an off-by-one in a mask width matches the wrong neighbour or misses the right one. In sequential mode it drives a lone B match, an A-then-B pair, a cycle that hits both channels while unarmed, and an arm followed by a configuration rewrite. A design that fires on the same-cycle double hit, or keeps the arm state after firing or after a write, shows flag B where none is expected. It also puts data in the upper bus half and clears one flag while the other is held, so that a design comparing the wrong lane or clearing both flags is caught.

// File: rtl/brkPkg.sv
package brkPkg;
  localparam int ADDR_W    = 32;
  localparam int ASID_W    = 8;
  localparam int BUS_DATA_W = 64;
  localparam int CMP_W     = 32;
  localparam int REG_W     = 32;
  localparam int RADDR_W   = 3;
  localparam int NUM_CH    = 2;
  localparam int CH_A      = 0;
  localparam int CH_B      = 1;

  // ignored low-bit counts for the address mask codes
  localparam int LOW_M1 = 10;
  localparam int LOW_M2 = 12;
  localparam int LOW_M3 = 16;
  localparam int LOW_M4 = 20;

  localparam logic [RADDR_W-1:0] REG_ADDR_A = 3'd0;
  localparam logic [RADDR_W-1:0] REG_CTL_A  = 3'd1;
  localparam logic [RADDR_W-1:0] REG_ADDR_B = 3'd2;
  localparam logic [RADDR_W-1:0] REG_CTL_B  = 3'd3;
  localparam logic [RADDR_W-1:0] REG_VAL_B  = 3'd4;
  localparam logic [RADDR_W-1:0] REG_MASK_B = 3'd5;
  localparam logic [RADDR_W-1:0] REG_MODE   = 3'd6;
  localparam logic [RADDR_W-1:0] REG_CLR    = 3'd7;

  typedef enum logic [2:0] {
    AM_ALL   = 3'd0,
    AM_LOW10 = 3'd1,
    AM_LOW12 = 3'd2,
    AM_LOW16 = 3'd3,
    AM_LOW20 = 3'd4,
    AM_NONE  = 3'd5
  } addrMaskE;

  typedef struct packed {
    logic              en;
    logic              afterExec;
    logic              sizeAny;
    logic [1:0]        size;
    logic [1:0]        dir;
    logic [1:0]        cyc;
    logic [ASID_W-1:0] asid;
    logic              asidAny;
    logic [2:0]        amask;
  } chanCtlT;

  localparam int CTL_W = $bits(chanCtlT);

  typedef struct packed {
    logic ldAddrA;
    logic ldCtlA;
    logic ldAddrB;
    logic ldCtlB;
    logic ldValB;
    logic ldMaskB;
  } cfgStrobeT;
endpackage

// File: rtl/brkChanCmp.sv
module brkChanCmp
  import brkPkg::*;
#(
  parameter int ADDR_WIDTH = brkPkg::ADDR_W,
  parameter int CMP_WIDTH  = brkPkg::CMP_W,
  parameter int REG_WIDTH  = brkPkg::REG_W,
  parameter bit HAS_DATA   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ldAddr,
  input  logic                  ldCtl,
  input  logic                  ldVal,
  input  logic                  ldMask,
  input  logic [REG_WIDTH-1:0]  wdata,
  input  logic                  busValid,
  input  logic [ADDR_WIDTH-1:0] busAddr,
  input  logic [ASID_W-1:0]     busAsid,
  input  logic [CMP_WIDTH-1:0]  busData,
  input  logic                  busIsInsn,
  input  logic                  busIsWrite,
  input  logic [1:0]            busSize,
  output logic                  match,
  output logic                  afterQual
);
  localparam logic [ADDR_WIDTH-1:0] ONES = {ADDR_WIDTH{1'b1}};

  chanCtlT               ctlQ;
  logic [ADDR_WIDTH-1:0] addrQ;
  logic [ADDR_WIDTH-1:0] careMask;
  logic addrOk, asidOk, cycOk, dirOk, sizeOk, dataOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      addrQ <= '0;
    end else begin
      if (ldAddr) addrQ <= wdata[ADDR_WIDTH-1:0];
      if (ldCtl)  ctlQ  <= chanCtlT'(wdata[CTL_W-1:0]);
    end
  end

  always_comb begin
    case (addrMaskE'(ctlQ.amask))
      AM_ALL:   careMask = ONES;
      AM_LOW10: careMask = ONES << LOW_M1;
      AM_LOW12: careMask = ONES << LOW_M2;
      AM_LOW16: careMask = ONES << LOW_M3;
      AM_LOW20: careMask = ONES << LOW_M4;
      default:  careMask = '0;
    endcase
  end

  always_comb begin
    addrOk = ((busAddr ^ addrQ) & careMask) == '0;
    asidOk = ctlQ.asidAny || (busAsid == ctlQ.asid);
    case (ctlQ.cyc)
      2'b01:   cycOk = busIsInsn;
      2'b10:   cycOk = !busIsInsn;
      default: cycOk = 1'b1;
    endcase
    case (ctlQ.dir)
      2'b01:   dirOk = !busIsWrite;
      2'b10:   dirOk = busIsWrite;
      default: dirOk = 1'b1;
    endcase
    sizeOk = ctlQ.sizeAny || (busSize == ctlQ.size);
  end

  generate
    if (HAS_DATA) begin : gData
      logic [CMP_WIDTH-1:0] valQ;
      logic [CMP_WIDTH-1:0] maskQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          valQ  <= '0;
          maskQ <= '0;
        end else begin
          if (ldVal)  valQ  <= wdata[CMP_WIDTH-1:0];
          if (ldMask) maskQ <= wdata[CMP_WIDTH-1:0];
        end
      end
      assign dataOk = ((busData ^ valQ) & ~maskQ) == '0;
    end else begin : gNoData
      logic unusedDataIn;
      assign unusedDataIn = ^{ldVal, ldMask, busData};
      assign dataOk = 1'b1;
    end
  endgenerate

  assign match     = busValid && ctlQ.en && addrOk && asidOk && cycOk
                     && dirOk && sizeOk && dataOk;
  assign afterQual = ctlQ.afterExec && busIsInsn;
endmodule

// File: rtl/brkDatapath.sv
module brkDatapath
  import brkPkg::*;
#(
  parameter int ADDR_WIDTH = brkPkg::ADDR_W,
  parameter int CMP_WIDTH  = brkPkg::CMP_W,
  parameter int REG_WIDTH  = brkPkg::REG_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobeT             strobe,
  input  logic [REG_WIDTH-1:0]  wdata,
  input  logic                  busValid,
  input  logic [ADDR_WIDTH-1:0] busAddr,
  input  logic [ASID_W-1:0]     busAsid,
  input  logic [CMP_WIDTH-1:0]  busData,
  input  logic                  busIsInsn,
  input  logic                  busIsWrite,
  input  logic [1:0]            busSize,
  output logic [NUM_CH-1:0]     match,
  output logic [NUM_CH-1:0]     afterQual
);
  logic [NUM_CH-1:0] ldAddr, ldCtl, ldVal, ldMask;

  assign ldAddr = {strobe.ldAddrB, strobe.ldAddrA};
  assign ldCtl  = {strobe.ldCtlB,  strobe.ldCtlA};
  assign ldVal  = {strobe.ldValB,  1'b0};
  assign ldMask = {strobe.ldMaskB, 1'b0};

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
      brkChanCmp #(
        .ADDR_WIDTH(ADDR_WIDTH),
        .CMP_WIDTH (CMP_WIDTH),
        .REG_WIDTH (REG_WIDTH),
        .HAS_DATA  (ch == CH_B)
      ) uChan (
        .clk       (clk),
        .rstN      (rstN),
        .ldAddr    (ldAddr[ch]),
        .ldCtl     (ldCtl[ch]),
        .ldVal     (ldVal[ch]),
        .ldMask    (ldMask[ch]),
        .wdata     (wdata),
        .busValid  (busValid),
        .busAddr   (busAddr),
        .busAsid   (busAsid),
        .busData   (busData),
        .busIsInsn (busIsInsn),
        .busIsWrite(busIsWrite),
        .busSize   (busSize),
        .match     (match[ch]),
        .afterQual (afterQual[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/brkControl.sv
module brkControl
  import brkPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [RADDR_W-1:0] cfgAddr,
  input  logic [1:0]         wrLow,
  input  logic [NUM_CH-1:0]  match,
  input  logic [NUM_CH-1:0]  afterQual,
  output cfgStrobeT          strobe,
  output logic               seqMode,
  output logic               armed,
  output logic [NUM_CH-1:0]  flags,
  output logic               brkAfter
);
  logic [NUM_CH-1:0] qualQ;
  logic [NUM_CH-1:0] setFlag;
  logic [NUM_CH-1:0] clrFlag;
  logic              cfgRewrite;
  logic              armNext;

  always_comb begin
    strobe.ldAddrA = cfgWrEn && (cfgAddr == REG_ADDR_A);
    strobe.ldCtlA  = cfgWrEn && (cfgAddr == REG_CTL_A);
    strobe.ldAddrB = cfgWrEn && (cfgAddr == REG_ADDR_B);
    strobe.ldCtlB  = cfgWrEn && (cfgAddr == REG_CTL_B);
    strobe.ldValB  = cfgWrEn && (cfgAddr == REG_VAL_B);
    strobe.ldMaskB = cfgWrEn && (cfgAddr == REG_MASK_B);
  end

  assign cfgRewrite = cfgWrEn && (cfgAddr != REG_CLR);
  assign clrFlag    = (cfgWrEn && (cfgAddr == REG_CLR)) ? wrLow : '0;

  always_comb begin
    setFlag[CH_A] = match[CH_A] && !seqMode;
    setFlag[CH_B] = match[CH_B] && (!seqMode || armed);
    armNext       = armed;
    if (cfgRewrite || !seqMode) begin
      armNext = 1'b0;
    end else if (armed && match[CH_B]) begin
      armNext = 1'b0;
    end else if (match[CH_A]) begin
      armNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqMode <= 1'b0;
      armed   <= 1'b0;
      flags   <= '0;
      qualQ   <= '0;
    end else begin
      if (cfgWrEn && (cfgAddr == REG_MODE)) seqMode <= wrLow[0];
      armed <= armNext;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (setFlag[ch]) begin
          flags[ch] <= 1'b1;
          qualQ[ch] <= afterQual[ch];
        end else if (clrFlag[ch]) begin
          flags[ch] <= 1'b0;
        end
      end
    end
  end

  assign brkAfter = |(flags & qualQ);
endmodule

// File: rtl/brkUnit.sv
module brkUnit
  import brkPkg::*;
#(
  parameter int ADDR_WIDTH  = brkPkg::ADDR_W,
  parameter int DATA_WIDTH  = brkPkg::BUS_DATA_W,
  parameter int CMP_WIDTH   = brkPkg::CMP_W,
  parameter int REG_WIDTH   = brkPkg::REG_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [RADDR_W-1:0]    cfgAddr,
  input  logic [REG_WIDTH-1:0]  cfgWrData,
  input  logic                  busValid,
  input  logic [ADDR_WIDTH-1:0] busAddr,
  input  logic [ASID_W-1:0]     busAsid,
  input  logic [DATA_WIDTH-1:0] busData,
  input  logic                  busIsInsn,
  input  logic                  busIsWrite,
  input  logic [1:0]            busSize,
  output logic                  brkReq,
  output logic                  brkAfter,
  output logic                  flagA,
  output logic                  flagB
);
  cfgStrobeT         strobe;
  logic [NUM_CH-1:0] match;
  logic [NUM_CH-1:0] afterQual;
  logic [NUM_CH-1:0] flags;
  logic              seqMode;
  logic              armed;
  logic              matchA;
  logic              matchB;
  logic              unusedDataHi;

  assign unusedDataHi = ^busData[DATA_WIDTH-1:CMP_WIDTH];

  brkDatapath #(
    .ADDR_WIDTH(ADDR_WIDTH),
    .CMP_WIDTH (CMP_WIDTH),
    .REG_WIDTH (REG_WIDTH)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (cfgWrData),
    .busValid  (busValid),
    .busAddr   (busAddr),
    .busAsid   (busAsid),
    .busData   (busData[CMP_WIDTH-1:0]),
    .busIsInsn (busIsInsn),
    .busIsWrite(busIsWrite),
    .busSize   (busSize),
    .match     (match),
    .afterQual (afterQual)
  );

  brkControl uControl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .wrLow    (cfgWrData[1:0]),
    .match    (match),
    .afterQual(afterQual),
    .strobe   (strobe),
    .seqMode  (seqMode),
    .armed    (armed),
    .flags    (flags),
    .brkAfter (brkAfter)
  );

  assign matchA = match[CH_A];
  assign matchB = match[CH_B];
  assign flagA  = flags[CH_A];
  assign flagB  = flags[CH_B];
  assign brkReq = |flags;
endmodule

// File: rtl/brkUnitChecker.sv
module brkUnitChecker
  import brkPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [RADDR_W-1:0] cfgAddr,
  input logic [REG_W-1:0]   cfgWrData,
  input logic               busValid,
  input logic               matchA,
  input logic               matchB,
  input logic               seqMode,
  input logic               armed,
  input logic               flagA,
  input logic               flagB
);
  assert_invalid_no_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (!matchA && !matchB));

  assert_indep_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!seqMode && matchA) |=> flagA);

  assert_seq_a_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && !flagA) |=> !flagA);

  assert_unarmed_no_fire_R10: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && !armed && !flagB) |=> !flagB);

  assert_rewrite_disarms_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgAddr != REG_CLR)) |=> !armed);

  assert_w1c_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (cfgAddr == REG_CLR) && cfgWrData[1] && !matchB) |=> !flagB);

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (flagA && !(cfgWrEn && (cfgAddr == REG_CLR) && cfgWrData[0])) |=> flagA);
endmodule

bind brkUnit brkUnitChecker uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .cfgAddr  (cfgAddr),
  .cfgWrData(cfgWrData),
  .busValid (busValid),
  .matchA   (matchA),
  .matchB   (matchB),
  .seqMode  (seqMode),
  .armed    (armed),
  .flagA    (flagA),
  .flagB    (flagB)
);

// File: tb/brkUnit_test.sv
module brkUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busAsid = '0;
  logic [63:0] busData = '0;
  logic        busIsInsn = 1'b0;
  logic        busIsWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic        brkReq, brkAfter, flagA, flagB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  brkUnit uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busValid(busValid), .busAddr(busAddr),
    .busAsid(busAsid), .busData(busData), .busIsInsn(busIsInsn),
    .busIsWrite(busIsWrite), .busSize(busSize), .brkReq(brkReq),
    .brkAfter(brkAfter), .flagA(flagA), .flagB(flagB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ctlWord(input logic en, input logic after,
      input logic sizeAny, input logic [1:0] size, input logic [1:0] dir,
      input logic [1:0] cyc, input logic [7:0] asid, input logic asidAny,
      input logic [2:0] amask);
    return {11'd0, en, after, sizeAny, size, dir, cyc, asid, asidAny, amask};
  endfunction

  localparam logic [31:0] CTL_ANY = {11'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 8'd0, 1'b1, 3'd5};

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic busCycle(input logic [31:0] a, input logic [7:0] asid,
      input logic [63:0] d, input logic insn, input logic wr, input logic [1:0] sz);
    busValid = 1'b1; busAddr = a; busAsid = asid; busData = d;
    busIsInsn = insn; busIsWrite = wr; busSize = sz;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic anyCycleA(input logic [31:0] a);
    busCycle(a, 8'h00, 64'h0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic clearFlags();
    writeReg(3'd7, 32'h3);
  endtask

  task automatic expectA(input string req, input string what, input logic e);
    chk(req, what, {31'd0, flagA}, {31'd0, e});
    clearFlags();
  endtask

  task automatic setupDefaults();
    writeReg(3'd6, 32'h0);
    writeReg(3'd1, 32'h0);
    writeReg(3'd3, 32'h0);
    writeReg(3'd5, 32'hFFFF_FFFF);
    clearFlags();
  endtask

  task automatic testReset();
    chk("R14", "flagA after reset", {31'd0, flagA}, 32'd0);
    chk("R14", "flagB after reset", {31'd0, flagB}, 32'd0);
    chk("R14", "brkReq after reset", {31'd0, brkReq}, 32'd0);
    chk("R14", "brkAfter after reset", {31'd0, brkAfter}, 32'd0);
    anyCycleA(32'h0);
    chk("R7", "reset channels disabled", {30'd0, flagB, flagA}, 32'd0);
  endtask

  task automatic testAddrMask();
    setupDefaults();
    writeReg(3'd0, 32'h1234_5678);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd0));
    anyCycleA(32'h1234_5678); expectA("R1", "code0 exact", 1'b1);
    anyCycleA(32'h1234_5679); expectA("R1", "code0 bit0 differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd1));
    anyCycleA(32'h1234_57FF); expectA("R1", "code1 low10 ignored", 1'b1);
    anyCycleA(32'h1234_5800); expectA("R1", "code1 bit11 differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd2));
    anyCycleA(32'h1234_5ABC); expectA("R1", "code2 low12 ignored", 1'b1);
    anyCycleA(32'h1234_6678); expectA("R1", "code2 bit12 differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd3));
    anyCycleA(32'h1234_FFFF); expectA("R1", "code3 low16 ignored", 1'b1);
    anyCycleA(32'h1235_0000); expectA("R1", "code3 bit16 differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd4));
    anyCycleA(32'h1230_0000); expectA("R1", "code4 low20 ignored", 1'b1);
    anyCycleA(32'h1240_0000); expectA("R1", "code4 bit20 differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd5));
    anyCycleA(32'hEDCB_A987); expectA("R1", "code5 all ignored", 1'b1);
  endtask

  task automatic testAsid();
    setupDefaults();
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 8'h5A, 0, 3'd5));
    busCycle(32'h0, 8'h5A, 64'h0, 0, 0, 0); expectA("R2", "asid equal", 1'b1);
    busCycle(32'h0, 8'h5B, 64'h0, 0, 0, 0); expectA("R2", "asid differs", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 8'h5A, 1, 3'd5));
    busCycle(32'h0, 8'h5B, 64'h0, 0, 0, 0); expectA("R2", "asid ignored", 1'b1);
  endtask

  task automatic testCycleDir();
    setupDefaults();
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 2'b01, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 1, 0, 0); expectA("R3", "insn-only on fetch", 1'b1);
    busCycle(32'h0, 0, 64'h0, 0, 0, 0); expectA("R3", "insn-only on operand", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 2'b10, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 1, 0, 0); expectA("R3", "operand-only on fetch", 1'b0);
    busCycle(32'h0, 0, 64'h0, 0, 0, 0); expectA("R3", "operand-only on operand", 1'b1);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 2'b01, 0, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 0, 0, 0); expectA("R4", "read-only on read", 1'b1);
    busCycle(32'h0, 0, 64'h0, 0, 1, 0); expectA("R4", "read-only on write", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 2'b10, 0, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 0, 1, 0); expectA("R4", "write-only on write", 1'b1);
    busCycle(32'h0, 0, 64'h0, 0, 0, 0); expectA("R4", "write-only on read", 1'b0);
  endtask

  task automatic testSize();
    setupDefaults();
    writeReg(3'd1, ctlWord(1, 0, 0, 2'd2, 0, 0, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 0, 0, 2'd2); expectA("R5", "longword match", 1'b1);
    busCycle(32'h0, 0, 64'h0, 0, 0, 2'd3); expectA("R5", "quadword mismatch", 1'b0);
    writeReg(3'd1, ctlWord(1, 0, 1, 2'd2, 0, 0, 0, 1, 3'd5));
    busCycle(32'h0, 0, 64'h0, 0, 0, 2'd0); expectA("R5", "size ignored", 1'b1);
  endtask

  task automatic testData();
    setupDefaults();
    writeReg(3'd3, CTL_ANY);
    writeReg(3'd4, 32'hCAFE_0000);
    writeReg(3'd5, 32'h0000_FFFF);
    busCycle(32'h0, 0, 64'h0000_0000_CAFE_1234, 0, 0, 0);
    chk("R6", "data match under mask", {31'd0, flagB}, 32'd1); clearFlags();
    busCycle(32'h0, 0, 64'h0000_0000_CAFF_1234, 0, 0, 0);
    chk("R6", "data mismatch in cared bit", {31'd0, flagB}, 32'd0); clearFlags();
    busCycle(32'h0, 0, 64'hDEAD_BEEF_CAFE_0000, 0, 0, 0);
    chk("R6", "upper data half ignored", {31'd0, flagB}, 32'd1); clearFlags();
  endtask

  task automatic testDisable();
    setupDefaults();
    writeReg(3'd1, CTL_ANY & ~32'h0010_0000);
    anyCycleA(32'h0);
    chk("R7", "disabled channel silent", {31'd0, flagA}, 32'd0);
    writeReg(3'd1, CTL_ANY);
    @(negedge clk);
    chk("R7", "invalid cycle no match", {31'd0, flagA}, 32'd0);
  endtask

  task automatic testIndependent();
    setupDefaults();
    writeReg(3'd0, 32'h0000_1000);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd0));
    writeReg(3'd2, 32'h0000_2000);
    writeReg(3'd3, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd0));
    anyCycleA(32'h0000_2000);
    chk("R8", "B alone fires in independent mode", {30'd0, flagB, flagA}, 32'd2);
    chk("R8", "request with flagB", {31'd0, brkReq}, 32'd1);
    anyCycleA(32'h0000_1000);
    chk("R8", "A fires, both flags", {30'd0, flagB, flagA}, 32'd3);
    @(negedge clk);
    chk("R12", "flags sticky", {30'd0, flagB, flagA}, 32'd3);
    writeReg(3'd7, 32'h1);
    chk("R12", "clear A only", {30'd0, flagB, flagA}, 32'd2);
    chk("R8", "request held by flagB", {31'd0, brkReq}, 32'd1);
    writeReg(3'd7, 32'h2);
    chk("R12", "clear B", {31'd0, brkReq}, 32'd0);
  endtask

  task automatic setupSeq();
    setupDefaults();
    writeReg(3'd0, 32'h0000_1000);
    writeReg(3'd1, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd0));
    writeReg(3'd2, 32'h0000_2000);
    writeReg(3'd3, ctlWord(1, 0, 1, 0, 0, 0, 0, 1, 3'd0));
    writeReg(3'd6, 32'h1);
  endtask

  task automatic testSequential();
    setupSeq();
    anyCycleA(32'h0000_2000);
    chk("R9", "B before A no fire", {31'd0, brkReq}, 32'd0);
    anyCycleA(32'h0000_1000);
    chk("R9", "A alone no request", {29'd0, brkReq, flagB, flagA}, 32'd0);
    anyCycleA(32'h0000_2000);
    chk("R9", "A then B fires", {29'd0, brkReq, flagB, flagA}, 32'd6);
    clearFlags();
    anyCycleA(32'h0000_2000);
    chk("R9", "arm cleared after fire", {31'd0, flagB}, 32'd0);
  endtask

  task automatic testSameCycle();
    setupDefaults();
    writeReg(3'd1, CTL_ANY);
    writeReg(3'd3, CTL_ANY);
    writeReg(3'd6, 32'h1);
    anyCycleA(32'h0);
    chk("R10", "double hit unarmed no fire", {30'd0, flagB, flagA}, 32'd0);
    anyCycleA(32'h0);
    chk("R10", "next double hit fires B", {30'd0, flagB, flagA}, 32'd2);
    clearFlags();
  endtask

  task automatic testDisarm();
    setupSeq();
    anyCycleA(32'h0000_1000);
    writeReg(3'd0, 32'h0000_1000);
    anyCycleA(32'h0000_2000);
    chk("R11", "rewrite disarms", {31'd0, flagB}, 32'd0);
    anyCycleA(32'h0000_1000);
    anyCycleA(32'h0000_2000);
    chk("R11", "rearm then fire", {31'd0, flagB}, 32'd1);
    clearFlags();
  endtask

  task automatic testAfter();
    setupDefaults();
    writeReg(3'd1, CTL_ANY | 32'h0008_0000);
    busCycle(32'h0, 0, 64'h0, 1, 0, 0);
    chk("R13", "after-exec on fetch", {31'd0, brkAfter}, 32'd1);
    clearFlags();
    chk("R13", "qualifier drops with flag", {31'd0, brkAfter}, 32'd0);
    busCycle(32'h0, 0, 64'h0, 0, 0, 0);
    chk("R13", "operand match no after", {30'd0, flagA, brkAfter}, 32'd2);
    clearFlags();
    writeReg(3'd1, CTL_ANY);
    busCycle(32'h0, 0, 64'h0, 1, 0, 0);
    chk("R13", "before-exec on fetch", {30'd0, flagA, brkAfter}, 32'd2);
    clearFlags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddrMask();
    testAsid();
    testCycleDir();
    testSize();
    testData();
    testDisable();
    testIndependent();
    testSequential();
    testSameCycle();
    testDisarm();
    testAfter();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule